// File: doc/BRIEF.md
# Pixel Row Readout Sequencer

This block produces the control waveforms that read an image sensor array of three-transistor pixels one row at a time, through a column double-sampling stage and a single shared ADC. For every row it resets the pixels, lets them integrate for a programmable number of cycles, and selects the row while the clamp and the sample-and-hold switches track the pixel level. It then raises the pixel reset again. That reset edge opens the clamp and starts the subtraction, which stores the difference on the column hold capacitors. After that the held columns go to the ADC one at a time: the block issues a start pulse with a column index and waits for the converter's done.

Two state machines share the work so that rows overlap. The front machine walks each row through `F_RESET` -> `F_INTEG` -> (`F_WAIT`) -> `F_TRACK` -> `F_SUB` and back to `F_RESET` for the next row. `F_INTEG` goes straight to `F_TRACK` when the converter is idle. Otherwise it goes to `F_WAIT`, and `F_WAIT` leaves for `F_TRACK` as soon as the converter is idle. The last `F_SUB` cycle is the handoff: it loads the row into the column machine, which steps `C_IDLE` -> `C_START` -> `C_BUSY`. On each done, `C_BUSY` returns to `C_START` for the next column, or goes to `C_IDLE` after the last column. Row i+1 therefore resets and integrates while row i is converted. Row i+1 is not transferred to the hold stage until every column of row i has been converted.

Top module: `pixel_row_sequencer`

## Requirements
- R1: While `rst_n` is low, `pix_rst` is 1; `row_sel`, `clamp`, `samp_hold`, `adc_start` and `frame_start` are 0; `row_idx`, `col_idx` and `conv_row` are 0.
- R2: After reset, the first row holds `pix_rst` high for exactly RST_CYC cycles. Every later high period of `pix_rst` lasts SUB_CYC + RST_CYC cycles, because the subtraction of one row runs straight into the reset of the next row.
- R3: When the converter is already idle, `row_sel` rises exactly N cycles after `pix_rst` falls, where N is the value of `integ_cycles`; a value of 0 is treated as 1.
- R4: `row_sel`, `clamp` and `samp_hold` rise together while `pix_rst` is low, and `clamp` stays high for exactly TRACK_CYC cycles.
- R5: `clamp` falls in the same cycle that `pix_rst` rises, while `row_sel` and `samp_hold` stay high. `row_sel` stays high for TRACK_CYC + SUB_CYC cycles in total.
- R6: In the cycle where `row_sel` and `samp_hold` fall, `adc_start` is 1, `col_idx` is 0 and `conv_row` equals the row that was just selected.
- R7: `adc_start` is a one-cycle pulse. In the cycle after each `adc_done`, `adc_start` is issued again with `col_idx` one higher, until column NUM_COLS-1 is done. The conversion then stops after exactly NUM_COLS starts.
- R8: `row_sel` never rises while the previous row is still being converted. If the last done of the previous row comes at cycle t, tracking of the next row starts no earlier than t+2.
- R9: `row_idx` advances by one at each handoff and wraps from NUM_ROWS-1 to 0. `frame_start` is high for one cycle, exactly at the handoff that wraps, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| integ_cycles | input | INTEG_W | Integration length in cycles (0 is treated as 1) |
| adc_done | input | 1 | Converter finished the current column |
| pix_rst | output | 1 | Pixel reset line of the addressed row |
| row_sel | output | 1 | Row select switch |
| clamp | output | 1 | Double-sampling clamp switch |
| samp_hold | output | 1 | Double-sampling sample-and-hold switch |
| row_idx | output | $clog2(NUM_ROWS) | Row under reset, integration or sampling |
| adc_start | output | 1 | One-cycle start pulse to the ADC |
| col_idx | output | $clog2(NUM_COLS) | Column multiplexer index |
| conv_row | output | $clog2(NUM_ROWS) | Row whose columns are being converted |
| frame_start | output | 1 | Pulse when the row index wraps to 0 |

## Verification
The critical coincidence is the last `adc_done` of row i landing in the very cycle that the integration count of row i+1 expires. In that case the front machine must pass through one `F_WAIT` cycle, where one cycle earlier it would have gone straight to tracking. The bench holds the converter latency at two cycles for a few rows and sweeps `integ_cycles` through 14..17. This places the final done before, on, and after the last integration cycle. The rising edge of `row_sel` is judged against the larger of the fall of `pix_rst` plus the integration length and the final done plus two.

// File: rtl/pixrow_pkg.sv
package pixrow_pkg;

    typedef enum logic [2:0] {
        F_RESET,
        F_INTEG,
        F_WAIT,
        F_TRACK,
        F_SUB
    } front_state_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_START,
        C_BUSY
    } conv_state_t;

    function automatic int bits_for(input int value);
        return (value < 2) ? 1 : $clog2(value + 1);
    endfunction

endpackage

// File: rtl/pixrow_front.sv
module pixrow_front
    import pixrow_pkg::*;
#(
    parameter int NUM_ROWS  = 144,
    parameter int INTEG_W   = 16,
    parameter int RST_CYC   = 4,
    parameter int TRACK_CYC = 8,
    parameter int SUB_CYC   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [INTEG_W-1:0]          integ_cycles,
    input  logic                        conv_busy,
    output logic                        pix_rst,
    output logic                        row_sel,
    output logic                        clamp,
    output logic                        samp_hold,
    output logic                        handoff,
    output logic [$clog2(NUM_ROWS)-1:0] row_idx,
    output logic                        frame_start
);

    localparam int ROW_W  = $clog2(NUM_ROWS);
    localparam int PH_MAX = (RST_CYC > TRACK_CYC)
                          ? ((RST_CYC > SUB_CYC) ? RST_CYC : SUB_CYC)
                          : ((TRACK_CYC > SUB_CYC) ? TRACK_CYC : SUB_CYC);
    localparam int PH_W   = bits_for(PH_MAX);
    localparam int CNT_W  = (INTEG_W > PH_W) ? INTEG_W : PH_W;
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] TRK_LAST = CNT_W'(TRACK_CYC - 1);
    localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(SUB_CYC - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

    front_state_t     state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] integ_last;

    assign integ_last = (integ_cycles == '0) ? '0 : CNT_W'(integ_cycles) - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= F_RESET;
            cnt         <= '0;
            row_idx     <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            unique case (state)
                F_RESET: begin
                    if (cnt == RST_LAST) begin
                        state <= F_INTEG;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                F_INTEG: begin
                    if (cnt == integ_last) begin
                        state <= conv_busy ? F_WAIT : F_TRACK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                F_WAIT: begin
                    if (!conv_busy) begin
                        state <= F_TRACK;
                    end
                end
                F_TRACK: begin
                    if (cnt == TRK_LAST) begin
                        state <= F_SUB;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                F_SUB: begin
                    if (cnt == SUB_LAST) begin
                        state       <= F_RESET;
                        cnt         <= '0;
                        row_idx     <= (row_idx == ROW_LAST) ? '0 : row_idx + 1'b1;
                        frame_start <= (row_idx == ROW_LAST);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= F_RESET;
                    cnt   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        pix_rst   = 1'b0;
        row_sel   = 1'b0;
        clamp     = 1'b0;
        samp_hold = 1'b0;
        handoff   = 1'b0;
        unique case (state)
            F_RESET: pix_rst = 1'b1;
            F_INTEG: ;
            F_WAIT:  ;
            F_TRACK: begin
                row_sel   = 1'b1;
                clamp     = 1'b1;
                samp_hold = 1'b1;
            end
            F_SUB: begin
                pix_rst   = 1'b1;
                row_sel   = 1'b1;
                samp_hold = 1'b1;
                handoff   = (cnt == SUB_LAST);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pixrow_colconv.sv
module pixrow_colconv
    import pixrow_pkg::*;
#(
    parameter int NUM_ROWS = 144,
    parameter int NUM_COLS = 176
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        handoff,
    input  logic [$clog2(NUM_ROWS)-1:0] handoff_row,
    input  logic                        adc_done,
    output logic                        conv_busy,
    output logic                        adc_start,
    output logic [$clog2(NUM_COLS)-1:0] col_idx,
    output logic [$clog2(NUM_ROWS)-1:0] conv_row
);

    localparam int COL_W = $clog2(NUM_COLS);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

    conv_state_t state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= C_IDLE;
            col_idx  <= '0;
            conv_row <= '0;
        end else begin
            unique case (state)
                C_IDLE: begin
                    if (handoff) begin
                        state    <= C_START;
                        col_idx  <= '0;
                        conv_row <= handoff_row;
                    end
                end
                C_START: state <= C_BUSY;
                C_BUSY: begin
                    if (adc_done) begin
                        if (col_idx == COL_LAST) begin
                            state <= C_IDLE;
                        end else begin
                            state   <= C_START;
                            col_idx <= col_idx + 1'b1;
                        end
                    end
                end
                default: state <= C_IDLE;
            endcase
        end
    end

    always_comb begin
        adc_start = 1'b0;
        conv_busy = 1'b1;
        unique case (state)
            C_IDLE:  conv_busy = 1'b0;
            C_START: adc_start = 1'b1;
            C_BUSY:  ;
            default: ;
        endcase
    end

endmodule

// File: rtl/pixel_row_sequencer.sv
module pixel_row_sequencer #(
    parameter int NUM_ROWS  = 144,
    parameter int NUM_COLS  = 176,
    parameter int INTEG_W   = 16,
    parameter int RST_CYC   = 4,
    parameter int TRACK_CYC = 8,
    parameter int SUB_CYC   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [INTEG_W-1:0]          integ_cycles,
    input  logic                        adc_done,
    output logic                        pix_rst,
    output logic                        row_sel,
    output logic                        clamp,
    output logic                        samp_hold,
    output logic [$clog2(NUM_ROWS)-1:0] row_idx,
    output logic                        adc_start,
    output logic [$clog2(NUM_COLS)-1:0] col_idx,
    output logic [$clog2(NUM_ROWS)-1:0] conv_row,
    output logic                        frame_start
);

    logic conv_busy;
    logic handoff;

    pixrow_front #(
        .NUM_ROWS  (NUM_ROWS),
        .INTEG_W   (INTEG_W),
        .RST_CYC   (RST_CYC),
        .TRACK_CYC (TRACK_CYC),
        .SUB_CYC   (SUB_CYC)
    ) u_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .integ_cycles (integ_cycles),
        .conv_busy    (conv_busy),
        .pix_rst      (pix_rst),
        .row_sel      (row_sel),
        .clamp        (clamp),
        .samp_hold    (samp_hold),
        .handoff      (handoff),
        .row_idx      (row_idx),
        .frame_start  (frame_start)
    );

    pixrow_colconv #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS)
    ) u_conv (
        .clk         (clk),
        .rst_n       (rst_n),
        .handoff     (handoff),
        .handoff_row (row_idx),
        .adc_done    (adc_done),
        .conv_busy   (conv_busy),
        .adc_start   (adc_start),
        .col_idx     (col_idx),
        .conv_row    (conv_row)
    );

endmodule

// File: rtl/pixrow_checker.sv
module pixrow_checker #(
    parameter int NUM_ROWS = 144,
    parameter int NUM_COLS = 176
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        pix_rst,
    input logic                        row_sel,
    input logic                        clamp,
    input logic                        samp_hold,
    input logic [$clog2(NUM_ROWS)-1:0] row_idx,
    input logic                        adc_start,
    input logic [$clog2(NUM_COLS)-1:0] col_idx,
    input logic                        frame_start,
    input logic                        conv_busy
);

    AST_TRACK_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        clamp |-> (row_sel && samp_hold && !pix_rst)); // R4

    AST_CLAMP_ON_RESET_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp) |-> ($rose(pix_rst) && row_sel && samp_hold)); // R5

    AST_HOLD_BEFORE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (!samp_hold && !row_sel)); // R6

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R7

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        col_idx <= ($clog2(NUM_COLS))'(NUM_COLS - 1)); // R7

    AST_NO_TRACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_sel) |-> !conv_busy); // R8

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx <= ($clog2(NUM_ROWS))'(NUM_ROWS - 1)); // R9

    AST_FRAME_AT_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (row_idx == '0 && pix_rst)); // R9

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R9

endmodule

bind pixel_row_sequencer pixrow_checker #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS)
) u_pixrow_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_rst     (pix_rst),
    .row_sel     (row_sel),
    .clamp       (clamp),
    .samp_hold   (samp_hold),
    .row_idx     (row_idx),
    .adc_start   (adc_start),
    .col_idx     (col_idx),
    .frame_start (frame_start),
    .conv_busy   (conv_busy)
);

// File: tb/pixel_row_sequencer_test.sv
`timescale 1ns/1ps
module pixel_row_sequencer_test;

    localparam int ROWS    = 4;
    localparam int COLS    = 6;
    localparam int IW      = 8;
    localparam int RST     = 3;
    localparam int TRK     = 4;
    localparam int SUB     = 2;
    localparam int RUN_ROWS = 20;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [IW-1:0]           integ_cycles = '0;
    logic                    adc_done = 1'b0;
    logic                    pix_rst, row_sel, clamp, samp_hold;
    logic                    adc_start, frame_start;
    logic [$clog2(ROWS)-1:0] row_idx, conv_row;
    logic [$clog2(COLS)-1:0] col_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int rows_handed = 0;
    int wait_n = 0;
    int starts_seen = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pixel_row_sequencer #(
        .NUM_ROWS (ROWS), .NUM_COLS (COLS), .INTEG_W (IW),
        .RST_CYC (RST), .TRACK_CYC (TRK), .SUB_CYC (SUB)
    ) uut (
        .clk (clk), .rst_n (rst_n), .integ_cycles (integ_cycles),
        .adc_done (adc_done), .pix_rst (pix_rst), .row_sel (row_sel),
        .clamp (clamp), .samp_hold (samp_hold), .row_idx (row_idx),
        .adc_start (adc_start), .col_idx (col_idx), .conv_row (conv_row),
        .frame_start (frame_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pick_len(input int k);
        case (k)
            0: return 0;
            1: return 1;
            2: return 40;
            3: return 5;
            4: return 14;
            5: return 15;
            6: return 16;
            7: return 17;
            default: return $urandom_range(30, 0);
        endcase
    endfunction

    function automatic int expected_track(input int fall, input int len, input int last_done);
        int a = fall + ((len == 0) ? 1 : len);
        int b = last_done + 2;
        return (a > b) ? a : b;
    endfunction

    // ADC model: latency 2 for conversions of rows 3..6, random 1..4 otherwise
    initial begin
        forever begin
            @(negedge clk);
            adc_done = 1'b0;
            if (wait_n > 0) begin
                wait_n--;
                if (wait_n == 0) adc_done = 1'b1;
            end else if (rst_n && adc_start) begin
                int row_no = starts_seen / COLS;
                starts_seen++;
                wait_n = (row_no >= 3 && row_no <= 6) ? 2 : $urandom_range(4, 1);
            end
        end
    end

    task automatic monitor();
        int cyc = 0;
        bit p_rst = 1'b1, p_sel = 1'b0, p_clamp = 1'b0;
        bit first_run = 1'b1;
        int rst_rise = 0, fall_cyc = 0, len_at_fall = 0;
        int sel_rise = 0, clamp_rise = 0;
        int last_final = -1000, next_start = -1, idle_at = -1;
        int exp_row = 0, exp_col = 0;
        forever begin
            bit sel_fell;
            if (pix_rst && !p_rst) rst_rise = cyc;
            if (!pix_rst && p_rst) begin
                chk("R2 reset length", cyc - rst_rise, first_run ? RST : SUB + RST);
                first_run = 1'b0;
                fall_cyc = cyc;
                len_at_fall = integ_cycles;
            end
            if (row_sel && !p_sel) begin
                int e = expected_track(fall_cyc, len_at_fall, last_final);
                if (last_final + 2 > fall_cyc + ((len_at_fall == 0) ? 1 : len_at_fall))
                    chk("R8 track after last done", cyc, e);
                else
                    chk("R3 integration length", cyc, e);
                chk("R4 switches at track", {clamp, samp_hold, pix_rst}, 3'b110);
                chk("R9 row index", row_idx, exp_row);
                sel_rise = cyc;
            end
            if (clamp && !p_clamp) clamp_rise = cyc;
            if (!clamp && p_clamp) begin
                chk("R4 track length", cyc - clamp_rise, TRK);
                chk("R5 clamp on reset edge", {pix_rst, p_rst, row_sel, samp_hold}, 4'b1011);
            end
            sel_fell = !row_sel && p_sel;
            if (sel_fell) begin
                chk("R5 select length", cyc - sel_rise, TRK + SUB);
                chk("R6 handoff start", {adc_start, samp_hold}, 2'b10);
                chk("R6 first column", col_idx, 0);
                chk("R6 conv row", conv_row, exp_row);
                chk("R9 frame pulse", frame_start, (exp_row == ROWS - 1) ? 1 : 0);
                exp_row = (exp_row == ROWS - 1) ? 0 : exp_row + 1;
                chk("R9 row advance", row_idx, exp_row);
                exp_col = 0;
                integ_cycles = IW'(pick_len(rows_handed + 1));
                rows_handed++;
            end else if (frame_start) begin
                chk("R9 stray frame pulse", 1, 0);
            end
            if (cyc == next_start) chk("R7 restart after done", adc_start, 1);
            if (cyc == idle_at) chk("R7 stop after last column", adc_start, 0);
            if (adc_start) begin
                chk("R7 column order", col_idx, exp_col);
                exp_col++;
            end
            if (adc_done) begin
                if (col_idx == COLS - 1) begin
                    last_final = cyc;
                    idle_at = cyc + 1;
                    chk("R7 starts per row", exp_col, COLS);
                end else begin
                    next_start = cyc + 1;
                end
            end
            p_rst = pix_rst;
            p_sel = row_sel;
            p_clamp = clamp;
            @(negedge clk);
            #1;
            cyc++;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0C1A));
        integ_cycles = IW'(pick_len(0));
        repeat (4) @(negedge clk);
        #1;
        chk("R1 reset strobes",
            {pix_rst, row_sel, clamp, samp_hold, adc_start, frame_start}, 6'b100000);
        chk("R1 reset indices", {row_idx, col_idx, conv_row}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        fork
            monitor();
        join_none
        wait (rows_handed >= RUN_ROWS);
        repeat (60) @(negedge clk);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d rows expected %0d", rows_handed, RUN_ROWS);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule